// File: doc/BRIEF.md
# DRAM Refresh Rate Scheduler

This block tells a DRAM access sequencer when to place an auto-refresh pair, so that both refresh limits of the memory hold. The first limit is a longest allowed gap between refreshes. The second is a ceiling on how many refreshes may fall inside a short sliding window. An interval timer counts the clock cycles since the most recent refresh, or since the most recent exit from self-refresh. As that count grows, the block raises a plain request and then an urgent request. The urgent request tells the sequencer to stop starting new access pairs and to refresh first.

A ring of eight per-slot lifetime counters records the last eight refreshes. While all eight of those refreshes still lie inside the burst window, the block withholds permission for a ninth. Permission is also withheld while the refresh-cycle guard is running after a refresh or a self-refresh exit, and while any bank is busy. A self-refresh exit leaves one refresh owed, and that refresh is requested urgently until it has been issued. Every time limit is given in nanoseconds and turned into cycles with ceiling rounding against the clock-period parameter. The cycle count since the last refresh is sent out to the low-power controller.

Top module: `refresh_scheduler`

## Requirements
- R1: `since_last` is 0 after reset. It is 0 in the cycle after an edge at which `refresh_issued` or `selfref_exit` is sampled high. Otherwise it rises by one per clock and saturates at 2^CNT_W-1.
- R2: `ref_req` is high whenever `since_last` >= ceil(EARLY_NS*1000/CLK_PS). It is also high whenever a self-refresh exit is still owed a refresh.
- R3: `ref_urgent` is high whenever `since_last` >= ceil(TREFI_NS*1000/CLK_PS) - ceil(MARGIN_NS*1000/CLK_PS). It is never high while `ref_req` is low.
- R4: `burst_block` is high when the last eight sampled refreshes all lie within the window. A refresh sampled at edge t counts through the cycle that ends at edge t+ceil(WINDOW_NS*1000/CLK_PS).
- R5: `rfc_busy` is high for exactly ceil(TRFC_NS*1000/CLK_PS) cycles after an edge at which `refresh_issued` or `selfref_exit` is sampled high.
- R6: `ref_allowed` is high exactly when `all_idle` is high, `rfc_busy` is low and `burst_block` is low.
- R7: A sampled `selfref_exit` makes a refresh owed, and `ref_urgent` stays high until a later `refresh_issued` is sampled. If `selfref_exit` and `refresh_issued` are sampled together, the exit wins and the refresh stays owed.
- R8: While `rst_n` is low, `ref_req`, `ref_urgent`, `rfc_busy` and `burst_block` are low and the refresh history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_issued | input | 1 | One-cycle pulse when an auto-refresh pair has been placed |
| selfref_exit | input | 1 | One-cycle pulse when the device leaves self-refresh |
| all_idle | input | 1 | All banks idle and all outputs high-impedance |
| since_last | output | CNT_W | Cycles since the last refresh or self-refresh exit (saturating) |
| ref_req | output | 1 | Refresh wanted |
| ref_urgent | output | 1 | Refresh must preempt new access pairs |
| rfc_busy | output | 1 | Refresh-cycle guard running; no command may follow yet |
| burst_block | output | 1 | Eight refreshes already inside the sliding window |
| ref_allowed | output | 1 | A refresh may be placed in this cycle |

## Verification
Two events can land on the same clock edge, and the bench drives both on purpose. In the first, a refresh is issued on the edge where the oldest of eight recorded refreshes leaves the window. The burst block must then stay high, because the second-oldest entry and the new one are still inside. In the second, a refresh lands on the edge where the urgent threshold would have been crossed, so urgent must never rise. A self-refresh exit sampled together with a refresh is driven as well, and the owed refresh must survive it. The bench's behavioural model keeps a queue of issue cycles and recomputes every output with integer arithmetic. The outputs are compared with that model on every clock.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // Nanoseconds to whole clock cycles, rounded up.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  // Bits needed for a down-counter holding values 0..max_val.
  function automatic int unsigned cnt_bits(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/refsched_interval_timer.sv
module refsched_interval_timer #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned EARLY_CYC = 488,
  parameter int unsigned URG_CYC   = 875
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             early_hit,
  output logic             late_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] EARLY_T = CNT_W'(EARLY_CYC);
  localparam logic [CNT_W-1:0] URG_T   = CNT_W'(URG_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (restart)        count <= '0;
    else if (count != CNT_MAX) count <= count + 1'b1;
  end

  assign early_hit = (count >= EARLY_T);
  assign late_hit  = (count >= URG_T);
endmodule

// File: rtl/refsched_rfc_guard.sv
module refsched_rfc_guard #(
  parameter int unsigned RFC_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned GW = refsched_pkg::cnt_bits(RFC_CYC);
  logic [GW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left_q <= '0;
    else if (start)       left_q <= GW'(RFC_CYC);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/refsched_burst_window.sv
module refsched_burst_window #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned WIN_CYC = 800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  output logic [DEPTH-1:0] slot_alive,
  output logic             full
);
  localparam int unsigned PTR_W  = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int unsigned LIFE_W = refsched_pkg::cnt_bits(WIN_CYC);

  logic [PTR_W-1:0] wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else if (issue) begin
      if (wr_ptr == PTR_W'(DEPTH - 1)) wr_ptr <= '0;
      else                             wr_ptr <= wr_ptr + 1'b1;
    end
  end

  // Slots are written in ring order, so the slot under wr_ptr is always the oldest.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [LIFE_W-1:0] life_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               life_q <= '0;
      else if (issue && wr_ptr == PTR_W'(g))    life_q <= LIFE_W'(WIN_CYC);
      else if (life_q != '0)                    life_q <= life_q - 1'b1;
    end
    assign slot_alive[g] = (life_q != '0);
  end

  assign full = &slot_alive;
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned TREFI_NS  = 3900,
  parameter int unsigned MARGIN_NS = 400,
  parameter int unsigned EARLY_NS  = 1950,
  parameter int unsigned WINDOW_NS = 3200,
  parameter int unsigned TRFC_NS   = 120,
  parameter int unsigned HIST      = 8,
  parameter int unsigned CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_issued,
  input  logic             selfref_exit,
  input  logic             all_idle,
  output logic [CNT_W-1:0] since_last,
  output logic             ref_req,
  output logic             ref_urgent,
  output logic             rfc_busy,
  output logic             burst_block,
  output logic             ref_allowed
);
  import refsched_pkg::*;

  localparam int unsigned TREFI_CYC  = ns_to_cycles(TREFI_NS, CLK_PS);
  localparam int unsigned MARGIN_CYC = ns_to_cycles(MARGIN_NS, CLK_PS);
  localparam int unsigned EARLY_CYC  = ns_to_cycles(EARLY_NS, CLK_PS);
  localparam int unsigned URG_CYC    = TREFI_CYC - MARGIN_CYC;
  localparam int unsigned WIN_CYC    = ns_to_cycles(WINDOW_NS, CLK_PS);
  localparam int unsigned RFC_CYC    = ns_to_cycles(TRFC_NS, CLK_PS);

  // Named internal events, visible to the bound checker.
  logic             restart_evt;
  logic             early_hit;
  logic             late_hit;
  logic             owed_q;
  logic [HIST-1:0]  slot_alive;

  assign restart_evt = refresh_issued | selfref_exit;

  refsched_interval_timer #(
    .CNT_W(CNT_W), .EARLY_CYC(EARLY_CYC), .URG_CYC(URG_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart_evt),
    .count(since_last), .early_hit(early_hit), .late_hit(late_hit)
  );

  refsched_rfc_guard #(.RFC_CYC(RFC_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .start(restart_evt), .busy(rfc_busy)
  );

  refsched_burst_window #(.DEPTH(HIST), .WIN_CYC(WIN_CYC)) u_window (
    .clk(clk), .rst_n(rst_n), .issue(refresh_issued),
    .slot_alive(slot_alive), .full(burst_block)
  );

  // A self-refresh exit owes one refresh; the exit wins a tie with an issue.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              owed_q <= 1'b0;
    else if (selfref_exit)   owed_q <= 1'b1;
    else if (refresh_issued) owed_q <= 1'b0;
  end

  assign ref_urgent  = late_hit | owed_q;
  assign ref_req     = early_hit | ref_urgent;
  assign ref_allowed = all_idle & ~rfc_busy & ~burst_block;
endmodule

// File: rtl/refsched_checker.sv
module refsched_checker #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned HIST  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             refresh_issued,
  input logic             selfref_exit,
  input logic             all_idle,
  input logic [CNT_W-1:0] since_last,
  input logic             ref_req,
  input logic             ref_urgent,
  input logic             rfc_busy,
  input logic             burst_block,
  input logic             ref_allowed,
  input logic [HIST-1:0]  slot_alive
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  AST_SINCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_issued || selfref_exit) |=> since_last == '0); // R1
  AST_SINCE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh_issued && !selfref_exit && since_last != SAT) |=> since_last == $past(since_last) + 1'b1); // R1
  AST_URGENT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ref_req); // R3
  AST_BLOCK_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_block) |-> $past(refresh_issued)); // R4
  AST_BLOCK_ALL_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    burst_block |-> $countones(slot_alive) == HIST); // R4
  AST_GUARD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_issued || selfref_exit) |=> rfc_busy); // R5
  AST_NO_ALLOW_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (rfc_busy || burst_block || !all_idle) |-> !ref_allowed); // R6
  AST_EXIT_OWES: assert property (@(posedge clk) disable iff (!rst_n)
    selfref_exit |=> ref_urgent); // R7
endmodule

bind refresh_scheduler refsched_checker #(.CNT_W(CNT_W), .HIST(HIST)) u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_issued(refresh_issued),
  .selfref_exit(selfref_exit), .all_idle(all_idle), .since_last(since_last),
  .ref_req(ref_req), .ref_urgent(ref_urgent), .rfc_busy(rfc_busy),
  .burst_block(burst_block), .ref_allowed(ref_allowed), .slot_alive(slot_alive)
);

// File: tb/tb_refresh_scheduler.sv
`timescale 1ns/1ps
module tb_refresh_scheduler;
  localparam int CLK_PS = 4000, TREFI_NS = 3900, MARGIN_NS = 400, EARLY_NS = 1950;
  localparam int WINDOW_NS = 3200, TRFC_NS = 120, HIST = 8, CNT_W = 12;

  function automatic int up_div(input int num, input int den);
    int q;
    q = num / den;
    if (q * den < num) q = q + 1;
    return q;
  endfunction

  int early_c, urg_c, win_c, rfc_c, sat_c;

  logic clk = 0, rst_n = 0, refresh_issued = 0, selfref_exit = 0, all_idle = 1;
  logic [CNT_W-1:0] since_last;
  logic ref_req, ref_urgent, rfc_busy, burst_block, ref_allowed;

  refresh_scheduler #(
    .CLK_PS(CLK_PS), .TREFI_NS(TREFI_NS), .MARGIN_NS(MARGIN_NS), .EARLY_NS(EARLY_NS),
    .WINDOW_NS(WINDOW_NS), .TRFC_NS(TRFC_NS), .HIST(HIST), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .refresh_issued(refresh_issued), .selfref_exit(selfref_exit),
    .all_idle(all_idle), .since_last(since_last), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .rfc_busy(rfc_busy), .burst_block(burst_block), .ref_allowed(ref_allowed)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // Behavioural reference model
  int cyc = 0, m_since = 0, m_rfc = 0;
  bit m_owed = 0;
  int stamps[$];

  initial begin
    early_c = up_div(EARLY_NS * 1000, CLK_PS);
    urg_c   = up_div(TREFI_NS * 1000, CLK_PS) - up_div(MARGIN_NS * 1000, CLK_PS);
    win_c   = up_div(WINDOW_NS * 1000, CLK_PS);
    rfc_c   = up_div(TRFC_NS * 1000, CLK_PS);
    sat_c   = (1 << CNT_W) - 1;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_since = 0; m_rfc = 0; m_owed = 0; stamps.delete();
    end else begin
      if (refresh_issued) begin
        stamps.push_back(cyc);
        if (stamps.size() > HIST) void'(stamps.pop_front());
      end
      if (refresh_issued || selfref_exit) begin
        m_since = 0; m_rfc = rfc_c;
      end else begin
        if (m_since < sat_c) m_since = m_since + 1;
        if (m_rfc > 0) m_rfc = m_rfc - 1;
      end
      if (selfref_exit) m_owed = 1;
      else if (refresh_issued) m_owed = 0;
    end
  end

  function automatic bit m_block();
    return (stamps.size() == HIST) && ((cyc - stamps[0]) < win_c);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison, away from both clock edges.
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      bit urg, req, blk, busy;
      urg  = (m_since >= urg_c) || m_owed;
      req  = (m_since >= early_c) || urg;
      blk  = m_block();
      busy = (m_rfc > 0);
      check("R1", "since_last", int'(since_last), m_since);
      check("R2", "ref_req", int'(ref_req), int'(req));
      check("R3", "ref_urgent", int'(ref_urgent), int'(urg));
      check("R4", "burst_block", int'(burst_block), int'(blk));
      check("R5", "rfc_busy", int'(rfc_busy), int'(busy));
      check("R6", "ref_allowed", int'(ref_allowed), int'(all_idle && !busy && !blk));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue_pulse();
    refresh_issued = 1; tick(1); refresh_issued = 0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      finished = 1; checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    #1;
    check("R8", "reset ref_req", int'(ref_req), 0);
    check("R8", "reset ref_urgent", int'(ref_urgent), 0);
    check("R8", "reset rfc_busy", int'(rfc_busy), 0);
    check("R8", "reset burst_block", int'(burst_block), 0);
    check("R8", "reset since_last", int'(since_last), 0);
    @(negedge clk); rst_n = 1;

    // Interval thresholds: plain then urgent request
    tick(urg_c + 5);
    #1 check("R3", "urgent after interval", int'(ref_urgent), 1);
    @(negedge clk); issue_pulse();
    #1 check("R3", "urgent cleared by refresh", int'(ref_urgent), 0);

    // Refresh on the edge where urgent would rise
    while (int'(since_last) != urg_c - 1) @(negedge clk);
    issue_pulse();
    #1 check("R3", "urgent never rose", int'(ref_urgent), 0);

    // Saturation of the interval counter
    tick(sat_c + 10);
    #1 check("R1", "since_last saturates", int'(since_last), sat_c);

    // Burst window: eight refreshes spaced past the guard time
    @(negedge clk);
    for (int i = 0; i < HIST; i++) begin
      issue_pulse(); tick(rfc_c + 9);
    end
    #1 check("R4", "block after eight", int'(burst_block), 1);
    @(negedge clk); all_idle = 0; tick(3);
    #1 check("R6", "no permission while busy banks", int'(ref_allowed), 0);
    @(negedge clk); all_idle = 1;

    // Refresh on the very edge the oldest entry leaves the window
    while ((cyc - stamps[0]) < win_c - 1) @(negedge clk);
    issue_pulse();
    #1 check("R4", "block holds on tie edge", int'(burst_block), 1);
    tick(win_c + 5);
    #1 check("R4", "block released", int'(burst_block), 0);

    // Self-refresh exit owes a refresh
    @(negedge clk); selfref_exit = 1; tick(1); selfref_exit = 0;
    #1 check("R7", "urgent after exit", int'(ref_urgent), 1);
    check("R5", "guard after exit", int'(rfc_busy), 1);
    tick(rfc_c + 2);
    #1 check("R7", "still owed", int'(ref_urgent), 1);
    @(negedge clk); issue_pulse();
    #1 check("R7", "owed refresh done", int'(ref_urgent), 0);

    // Exit and refresh sampled together: exit wins
    tick(rfc_c + 2);
    @(negedge clk); selfref_exit = 1; refresh_issued = 1; tick(1);
    selfref_exit = 0; refresh_issued = 0;
    #1 check("R7", "tie keeps refresh owed", int'(ref_urgent), 1);
    tick(rfc_c + 2);
    @(negedge clk); issue_pulse();
    #1 check("R7", "cleared after tie", int'(ref_urgent), 0);
    tick(20);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule